// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by requiring a keyed restart inside a time window. A 25-bit up-counter advances once per prescaled tick. The tick rate is set by a divider of 1 to 8. A 3-bit period select fixes the terminal count. A 3-bit window select fixes how much of that period is closed: inside the closed part a restart is not allowed. Three things count as a fault: the counter reaching the terminal count, a restart while the window is closed, and a restart written with a wrong key. On a fault the block either pulses a reset request or sets a sticky interrupt flag, as configured.

An interval mode turns the watchdog checking off. In that mode each pass through the period sets the interrupt flag, and the counter wraps and keeps running. With auto-stop enabled, the sleep input freezes the prescaler and the counter. The configuration arrives as plain level inputs, the way a register file would hold them. A restart is a one-cycle write strobe with an 8-bit key.

Top module: `winwatch`

## Requirements
- R1: After reset, and on any cycle after `en` is sampled low, `count` is 0; after reset `reset_req` and `irq_flag` are 0.
- R2: With enable high, `count` advances by one every `div_sel`+1 clock cycles. `div_sel` is 3 bits and gives divide-by 1 to 8.
- R3: `div_sel` is captured only while `en` is low; changes while enabled have no effect on the tick rate.
- R4: `period_sel` values 0..7 give terminal counts TC of 2^6, 2^8, 2^10, 2^12, 2^15, 2^18, 2^21 and 2^25 ticks. The tick that would take `count` to TC is an expiry, and `count` becomes 0 on that tick.
- R5: `window_sel` value w closes the window for the first TC*w/8 counts (w=0 never closes it). A restart with the correct key while `count` >= TC*w/8 clears `count` and the prescaler and raises no fault.
- R6: In watchdog mode, a correctly keyed restart while `count` < TC*w/8 is a fault.
- R7: The restart key is 8'hA5; a restart write with any other key is a fault.
- R8: With `fault_to_irq`=0, a fault gives a `reset_req` pulse of exactly one cycle, high in the cycle after the fault. With `fault_to_irq`=1, a fault sets `irq_flag` instead and `reset_req` stays low.
- R9: `irq_flag` holds until `irq_clr` is sampled high. A set in the same cycle as `irq_clr` wins.
- R10: With `interval_mode`=1, `reset_req` never rises, each expiry sets `irq_flag`, `count` wraps to 0 and keeps counting, and restart writes are ignored.
- R11: With `autostop`=1 and `sleep`=1, `count` holds its value; with `autostop`=0, `sleep` has no effect.
- R12: After any watchdog fault, `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low clears the counter and loads the divider |
| interval_mode | input | 1 | 1 = interval timer, 0 = watchdog |
| fault_to_irq | input | 1 | Fault action: 1 = interrupt flag, 0 = reset request |
| autostop | input | 1 | Allow `sleep` to freeze the count |
| sleep | input | 1 | Sleep indication |
| period_sel | input | 3 | Terminal count select |
| window_sel | input | 3 | Closed-window fraction select (eighths) |
| div_sel | input | 3 | Prescaler divide value minus one |
| kick_we | input | 1 | Restart write strobe |
| kick_key | input | 8 | Key carried with the restart write |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| count | output | 25 | Current counter value |
| reset_req | output | 1 | One-cycle reset request |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench sweeps every window select at one period and kicks one count before and exactly at the window edge. A design with an off-by-one in the limit would fault on the legal kick or accept the early one. It sweeps all eight divider values and the four shortest periods, and it expects each expiry on one exact cycle, which catches a prescaler that reloads late or a terminal compare off by one. It also covers a divider change made while enabled, which must be ignored, and an interrupt clear that lands on the same cycle as an expiry, where a wrong priority would lose the interrupt. Interval mode, key mismatch and sleep freezing are checked by reading the count and outputs at the ports.

// File: rtl/winwatch_pkg.sv
package winwatch_pkg;

  // log2 of the terminal count for each period select
  function automatic int unsigned period_log2(input logic [2:0] sel);
    case (sel)
      3'd0:    return 6;
      3'd1:    return 8;
      3'd2:    return 10;
      3'd3:    return 12;
      3'd4:    return 15;
      3'd5:    return 18;
      3'd6:    return 21;
      default: return 25;
    endcase
  endfunction

  function automatic logic [31:0] term_count(input logic [2:0] sel);
    return 32'd1 << period_log2(sel);
  endfunction

  // first count value at which a restart is legal
  function automatic logic [31:0] closed_limit(input logic [2:0] psel,
                                               input logic [2:0] wsel);
    return (term_count(psel) >> 3) * 32'(wsel);
  endfunction

endpackage

// File: rtl/winwatch_prescale.sv
module winwatch_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] pre_q;

  assign tick = en && !hold && (pre_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (!en) div_q <= div_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (!en || clr) pre_q <= '0;
    else if (tick)       pre_q <= '0;
    else if (!hold)      pre_q <= pre_q + ONE;
  end

  // R3: divider frozen while enabled
  a_r3_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(div_q));

endmodule

// File: rtl/winwatch_count.sv
module winwatch_count #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             clr,
  input  logic [31:0]      term,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;
  logic [31:0]      count_ext;

  assign count_ext = 32'(count_q);
  assign expire    = tick && (count_ext == term - 32'd1);
  assign count     = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= '0;
    else if (!en || clr)     count_q <= '0;
    else if (tick && expire) count_q <= '0;
    else if (tick)           count_q <= count_q + ONE;
  end

  // R1: disabled counter reads zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count_q == '0));

endmodule

// File: rtl/winwatch_fault.sv
module winwatch_fault #(
  parameter int              KEY_W    = 8,
  parameter logic [KEY_W-1:0] KICK_KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             interval_mode,
  input  logic             fault_to_irq,
  input  logic             expire,
  input  logic             kick_we,
  input  logic [KEY_W-1:0] kick_key,
  input  logic             window_open,
  input  logic             irq_clr,
  output logic             kick_good,
  output logic             kick_viol,
  output logic             reset_req,
  output logic             irq_flag
);
  logic kick_act;
  logic key_ok;
  logic wd_fault;
  logic interval_evt;
  logic irq_set;

  assign kick_act     = en && !interval_mode && kick_we;
  assign key_ok       = (kick_key == KICK_KEY);
  assign kick_good    = kick_act && key_ok && window_open;
  assign kick_viol    = kick_act && !(key_ok && window_open);
  assign wd_fault     = en && !interval_mode && ((expire && !kick_good) || kick_viol);
  assign interval_evt = en && interval_mode && expire;
  assign irq_set      = (wd_fault && fault_to_irq) || interval_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= wd_fault && !fault_to_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (irq_set) irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  // R9: flag stays set until cleared
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R10: no reset request in interval mode
  a_r10_no_reset_interval: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_mode && $past(interval_mode)) |-> !reset_req);

endmodule

// File: rtl/winwatch.sv
module winwatch #(
  parameter int              CNT_W    = 25,
  parameter int              SEL_W    = 3,
  parameter int              DIV_W    = 3,
  parameter int              KEY_W    = 8,
  parameter logic [KEY_W-1:0] KICK_KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             interval_mode,
  input  logic             fault_to_irq,
  input  logic             autostop,
  input  logic             sleep,
  input  logic [SEL_W-1:0] period_sel,
  input  logic [SEL_W-1:0] window_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             kick_we,
  input  logic [KEY_W-1:0] kick_key,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic             reset_req,
  output logic             irq_flag
);
  import winwatch_pkg::*;

  logic        hold;
  logic        tick;
  logic        expire;
  logic        kick_good;
  logic        kick_viol;
  logic        restart_clr;
  logic        window_open;
  logic [31:0] term;
  logic [31:0] limit;

  assign hold        = autostop && sleep;
  assign term        = term_count(3'(period_sel));
  assign limit       = closed_limit(3'(period_sel), 3'(window_sel));
  assign window_open = (32'(count) >= limit);
  assign restart_clr = kick_good || kick_viol;

  winwatch_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .hold    (hold),
    .clr     (restart_clr),
    .div_sel (div_sel),
    .tick    (tick)
  );

  winwatch_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .tick   (tick),
    .clr    (restart_clr),
    .term   (term),
    .count  (count),
    .expire (expire)
  );

  winwatch_fault #(.KEY_W(KEY_W), .KICK_KEY(KICK_KEY)) u_flt (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .interval_mode (interval_mode),
    .fault_to_irq  (fault_to_irq),
    .expire        (expire),
    .kick_we       (kick_we),
    .kick_key      (kick_key),
    .window_open   (window_open),
    .irq_clr       (irq_clr),
    .kick_good     (kick_good),
    .kick_viol     (kick_viol),
    .reset_req     (reset_req),
    .irq_flag      (irq_flag)
  );

  // R11: frozen count in auto-stop sleep
  a_r11_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && autostop && sleep && !kick_we) |=> $stable(count));

  // R6: keyed restart in closed window leads to a fault
  a_r6_early_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !interval_mode && kick_we && kick_key == KICK_KEY && !window_open)
      |=> (reset_req || irq_flag));

  // R12: counter is zero when a reset request is out
  a_r12_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (count == '0));

endmodule

// File: tb/winwatch_test.sv
`timescale 1ns/1ps
module winwatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, interval_mode = 1'b0, fault_to_irq = 1'b0;
  logic        autostop = 1'b0, sleep = 1'b0;
  logic [2:0]  period_sel = '0, window_sel = '0, div_sel = '0;
  logic        kick_we = 1'b0;
  logic [7:0]  kick_key = '0;
  logic        irq_clr = 1'b0;
  logic [24:0] count;
  logic        reset_req, irq_flag;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  winwatch uut (.*);

  function automatic int tc_of(input int p);
    int lg[8] = '{6, 8, 10, 12, 15, 18, 21, 25};
    return 1 << lg[p];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic restart_en();
    en = 1'b0;
    step(2);
    en = 1'b1;
  endtask

  task automatic kick(input logic [7:0] key);
    kick_we = 1'b1; kick_key = key;
    step(1);
    kick_we = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset count", count, 0);
    chk("R1 reset req", reset_req, 0);
    chk("R1 reset irq", irq_flag, 0);

    // R4 R8: expiry in reset mode, four periods
    for (int p = 0; p < 4; p++) begin
      period_sel = 3'(p); fault_to_irq = 1'b0;
      restart_en();
      step(tc_of(p) - 1);
      chk("R4 count before expiry", count, tc_of(p) - 1);
      chk("R8 no req before expiry", reset_req, 0);
      step(1);
      chk("R8 req at expiry", reset_req, 1);
      chk("R4 wrap to zero", count, 0);
      step(1);
      chk("R8 single pulse", reset_req, 0);
    end

    // R2: divider sweep, irq mode
    period_sel = 3'd0; fault_to_irq = 1'b1;
    for (int d = 1; d <= 8; d++) begin
      div_sel = 3'(d - 1);
      restart_en();
      step(64 * d - 1);
      chk("R2 count before expiry", count, 63);
      chk("R2 irq before expiry", irq_flag, 0);
      step(1);
      chk("R2 irq at expiry", irq_flag, 1);
      chk("R8 no req in irq mode", reset_req, 0);
      clear_irq();
      chk("R9 cleared", irq_flag, 0);
    end

    // R3: divider change while enabled ignored
    div_sel = 3'd0;
    restart_en();
    step(1);
    div_sel = 3'd7;
    step(62);
    chk("R3 count rate kept", count, 63);
    step(1);
    chk("R3 expiry on time", irq_flag, 1);
    clear_irq();
    div_sel = 3'd0;

    // R5 R6 R12: window sweep at period 1
    period_sel = 3'd1;
    for (int w = 0; w < 8; w++) begin
      int lim;
      lim = 32 * w;
      window_sel = 3'(w);
      if (w > 0) begin
        restart_en();
        step(lim - 1);
        kick(8'hA5);
        chk("R6 early kick faults", irq_flag, 1);
        chk("R12 count zero after fault", count, 0);
        clear_irq();
      end
      restart_en();
      step(lim);
      chk("R5 at window edge", count, lim);
      kick(8'hA5);
      chk("R5 legal kick no fault", irq_flag, 0);
      chk("R5 legal kick clears", count, 0);
    end

    // R7: wrong key in open window
    period_sel = 3'd0; window_sel = 3'd0; fault_to_irq = 1'b0;
    restart_en();
    step(10);
    kick(8'h5A);
    chk("R7 bad key req", reset_req, 1);
    chk("R12 count zero after bad key", count, 0);
    step(1);
    chk("R7 pulse ends", reset_req, 0);

    // R10 R9: interval mode
    interval_mode = 1'b1;
    restart_en();
    step(20);
    kick(8'hA5);
    chk("R10 kick ignored", count, 21);
    chk("R10 no irq from kick", irq_flag, 0);
    step(42);
    chk("R10 count", count, 63);
    step(1);
    chk("R10 irq at period", irq_flag, 1);
    chk("R10 wraps", count, 0);
    chk("R10 no reset", reset_req, 0);
    step(62);
    irq_clr = 1'b1;
    step(1);
    chk("R9 clear works", irq_flag, 0);
    step(1);
    irq_clr = 1'b0;
    chk("R9 set wins over clear", irq_flag, 1);
    chk("R10 second wrap", count, 0);
    chk("R10 still no reset", reset_req, 0);
    clear_irq();
    interval_mode = 1'b0;

    // R11: auto-stop in sleep
    fault_to_irq = 1'b1;
    autostop = 1'b1;
    restart_en();
    step(5);
    chk("R11 before sleep", count, 5);
    sleep = 1'b1;
    step(20);
    chk("R11 frozen", count, 5);
    sleep = 1'b0;
    step(3);
    chk("R11 resumes", count, 8);
    autostop = 1'b0; sleep = 1'b1;
    step(4);
    chk("R11 sleep ignored", count, 12);
    sleep = 1'b0;

    // R1: disable clears
    en = 1'b0;
    step(1);
    chk("R1 disabled zero", count, 0);
    step(5);
    chk("R1 stays zero", count, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule